// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block runs the slew-rate calibration of a high-speed transmitter in hardware. A one-cycle start pulse sets off a fixed sequence. The block turns on the on-chip ring oscillator and lets it settle. It then starts the free-running clock, loads the measurement window of an external frequency meter and enables the meter. Next it polls the meter's valid flag at a fixed interval, up to a total timeout, and captures the count. After that it turns the meter and the free-running clock off, derives a small slew code, writes that code into the transmitter control word and turns the oscillator off. A one-cycle done pulse ends the sequence.

The code is a rounded ratio that uses the captured count, a reference frequency in MHz and a coefficient. The reference frequency and the coefficient are inputs, so that integration can keep the usual values of 26 and 17 or use others. Two divisions run on one sequential divider. When the count is zero, the block uses a fixed fallback code. When a nonzero forced code is presented, the whole measurement is bypassed. All delays are counted in cycles of the block's own clock, and a parameter gives that clock's frequency.

Top module: `srcal_seq`

## Requirements
- R1: A start accepted while idle with a zero forced code sets the oscillator bit (ctrl_o bit 3). After SETTLE_US×CLK_MHZ cycles it sets frck_en_o and drives meter_window_o to 1024. One cycle later it sets meter_en_o.
- R2: With meter_en_o high, meter_valid_i is sampled once every POLL_US×CLK_MHZ cycles. At the first sample that finds it high, meter_count_i is captured and meter_en_o drops on the next edge. frck_en_o drops one edge after that.
- R3: If the flag is still low at the sample numbered TIMEOUT_US/POLL_US, the count present at that sample is captured anyway and the sequence goes on. timeout_o is then high from that point until the next accepted start.
- R4: For a nonzero count C, the code equals ((ref×coef×1024) div C + 500) div 1000, where div is integer division. Any result above 7 saturates to 7.
- R5: A captured count of zero gives the code 3.
- R6: A start with a nonzero force_code_i produces no oscillator, free-running clock or meter activity. The forced value becomes the code, and done_o is high two cycles after the start edge.
- R7: The code sits in ctrl_o bits [2:0] and is also given on code_o. It holds until the next calibration writes it. The oscillator bit clears on the same edge on which done_o rises.
- R8: done_o is a single-cycle pulse, issued once per accepted start.
- R9: A start pulse that arrives while a sequence is running is ignored. It does not change the result, the timing or the number of done pulses.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; used only while idle |
| force_code_i | input | CODE_W | Nonzero value bypasses measurement and becomes the code |
| ref_mhz_i | input | REF_W | Reference frequency in MHz for the code formula |
| coef_i | input | COEF_W | Coefficient for the code formula |
| meter_valid_i | input | 1 | Meter result valid flag |
| meter_count_i | input | CNT_W | Meter count |
| ctrl_o | output | CODE_W+1 | Transmitter control word: oscillator enable on top, code below |
| frck_en_o | output | 1 | Free-running clock enable |
| meter_en_o | output | 1 | Frequency meter enable |
| meter_window_o | output | WIN_FIELD_W | Meter cycle-count window |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| code_o | output | CODE_W | Current slew code |
| timeout_o | output | 1 | Last measurement ended by timeout |

## Verification
The start input is sampled at the first edge after it is driven. The meter enable is then due SETTLE+1 edges after that edge. It stays high for POLL+1 edges when valid is already present, and for NPOLL×POLL+1 edges on a timeout. The free-running clock falls exactly one edge after the meter enable, and on the forced path done is due two edges after the start. The bench drives inputs on falling edges and counts falling edges from the start, so every one of these edge counts is compared exactly. The code and the timeout flag are compared only after done has been seen. Because the two divisions take a data-independent but long time, the bench places no exact cycle bound on done for the measured path.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ARM,
    ST_POLL,
    ST_MOFF,
    ST_FOFF,
    ST_DIV1,
    ST_DIV2,
    ST_WRITE,
    ST_END
  } srcal_state_e;

endpackage

// File: rtl/srcal_timer.sv
module srcal_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         tick_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign tick_o = (cnt_q == W'(1));

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int SW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [SW-1:0] steps_q;
  logic          run_q;
  logic          done_q;
  logic [W:0]    shifted;
  logic [W:0]    trial;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dsr_q   <= '0;
      steps_q <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q   <= '0;
        quo_q   <= dividend_i;
        dsr_q   <= divisor_i;
        steps_q <= SW'(W);
        run_q   <= 1'b1;
      end else if (run_q) begin
        if (!trial[W]) begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        steps_q <= steps_q - SW'(1);
        if (steps_q == SW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
  import srcal_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int SETTLE_US     = 1,
  parameter int POLL_US       = 10,
  parameter int TIMEOUT_US    = 200,
  parameter int WINDOW        = 1024,
  parameter int WIN_FIELD_W   = 24,
  parameter int CNT_W         = 24,
  parameter int REF_W         = 16,
  parameter int COEF_W        = 16,
  parameter int CODE_W        = 3,
  parameter int FALLBACK_CODE = 3,
  parameter int ROUND_DIV     = 1000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic [CODE_W-1:0]      force_code_i,
  input  logic [REF_W-1:0]       ref_mhz_i,
  input  logic [COEF_W-1:0]      coef_i,
  input  logic                   meter_valid_i,
  input  logic [CNT_W-1:0]       meter_count_i,
  output logic [CODE_W:0]        ctrl_o,
  output logic                   frck_en_o,
  output logic                   meter_en_o,
  output logic [WIN_FIELD_W-1:0] meter_window_o,
  output logic                   done_o,
  output logic [CODE_W-1:0]      code_o,
  output logic                   timeout_o
);

  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US;
  localparam int POLL_CYC   = CLK_MHZ * POLL_US;
  localparam int NPOLLS     = TIMEOUT_US / POLL_US;
  localparam int TMR_W      = $clog2(SETTLE_CYC + POLL_CYC + 1);
  localparam int PN_W       = $clog2(NPOLLS + 1);
  localparam int WIN_W      = $clog2(WINDOW + 1);
  localparam int NUM_W      = REF_W + COEF_W + WIN_W;
  localparam int DIV_W      = NUM_W + 1;
  localparam int CODE_MAX   = (1 << CODE_W) - 1;

  srcal_state_e      state_q;
  logic              osc_q;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_calc_q;
  logic              frck_q;
  logic              meter_q;
  logic [WIN_FIELD_W-1:0] win_q;
  logic              done_q;
  logic              to_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REF_W-1:0]  ref_q;
  logic [COEF_W-1:0] coef_q;
  logic [PN_W-1:0]   poll_n_q;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_tick;
  logic              div_go_q;
  logic [DIV_W-1:0]  div_a_q;
  logic [DIV_W-1:0]  div_b_q;
  logic              div_done;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_W-1:0]  numer;
  logic              accept_meas;
  logic              last_poll;

  assign numer = NUM_W'(ref_q) * NUM_W'(coef_q) * NUM_W'(WINDOW);
  assign accept_meas = (state_q == ST_IDLE) && start_i && (force_code_i == '0);
  assign last_poll   = (poll_n_q == PN_W'(NPOLLS - 1));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TMR_W'(POLL_CYC);
    if (accept_meas) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(SETTLE_CYC);
    end else if (state_q == ST_ARM) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_POLL && tmr_tick && !meter_valid_i && !last_poll) begin
      tmr_load = 1'b1;
    end
  end

  srcal_timer #(.W(TMR_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .tick_o (tmr_tick)
  );

  srcal_div #(.W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .start_i    (div_go_q),
    .dividend_i (div_a_q),
    .divisor_i  (div_b_q),
    .done_o     (div_done),
    .quot_o     (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      osc_q       <= 1'b0;
      code_q      <= '0;
      code_calc_q <= '0;
      frck_q      <= 1'b0;
      meter_q     <= 1'b0;
      win_q       <= '0;
      done_q      <= 1'b0;
      to_q        <= 1'b0;
      cnt_q       <= '0;
      ref_q       <= '0;
      coef_q      <= '0;
      poll_n_q    <= '0;
      div_go_q    <= 1'b0;
      div_a_q     <= '0;
      div_b_q     <= '0;
    end else begin
      done_q   <= 1'b0;
      div_go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            to_q <= 1'b0;
            if (force_code_i != '0) begin
              code_calc_q <= force_code_i;
              state_q     <= ST_WRITE;
            end else begin
              osc_q   <= 1'b1;
              ref_q   <= ref_mhz_i;
              coef_q  <= coef_i;
              state_q <= ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (tmr_tick) begin
            frck_q  <= 1'b1;
            win_q   <= WIN_FIELD_W'(WINDOW);
            state_q <= ST_ARM;
          end
        end
        ST_ARM: begin
          meter_q  <= 1'b1;
          poll_n_q <= '0;
          state_q  <= ST_POLL;
        end
        ST_POLL: begin
          if (tmr_tick) begin
            poll_n_q <= poll_n_q + PN_W'(1);
            if (meter_valid_i) begin
              cnt_q   <= meter_count_i;
              state_q <= ST_MOFF;
            end else if (last_poll) begin
              cnt_q   <= meter_count_i;
              to_q    <= 1'b1;
              state_q <= ST_MOFF;
            end
          end
        end
        ST_MOFF: begin
          meter_q <= 1'b0;
          state_q <= ST_FOFF;
        end
        ST_FOFF: begin
          frck_q <= 1'b0;
          if (cnt_q == '0) begin
            code_calc_q <= CODE_W'(FALLBACK_CODE);
            state_q     <= ST_WRITE;
          end else begin
            div_a_q  <= DIV_W'(numer);
            div_b_q  <= DIV_W'(cnt_q);
            div_go_q <= 1'b1;
            state_q  <= ST_DIV1;
          end
        end
        ST_DIV1: begin
          if (div_done) begin
            div_a_q  <= div_q + DIV_W'(ROUND_DIV / 2);
            div_b_q  <= DIV_W'(ROUND_DIV);
            div_go_q <= 1'b1;
            state_q  <= ST_DIV2;
          end
        end
        ST_DIV2: begin
          if (div_done) begin
            if (div_q > DIV_W'(CODE_MAX)) code_calc_q <= CODE_W'(CODE_MAX);
            else                          code_calc_q <= div_q[CODE_W-1:0];
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          code_q  <= code_calc_q;
          state_q <= ST_END;
        end
        ST_END: begin
          osc_q   <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o         = {osc_q, code_q};
  assign code_o         = code_q;
  assign frck_en_o      = frck_q;
  assign meter_en_o     = meter_q;
  assign meter_window_o = win_q;
  assign done_o         = done_q;
  assign timeout_o      = to_q;

endmodule

// File: rtl/srcal_seq_chk.sv
module srcal_seq_chk #(
  parameter int CODE_W      = 3,
  parameter int WINDOW      = 1024,
  parameter int WIN_FIELD_W = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CODE_W:0]        ctrl_o,
  input logic                   frck_en_o,
  input logic                   meter_en_o,
  input logic [WIN_FIELD_W-1:0] meter_window_o,
  input logic                   done_o,
  input logic                   timeout_o
);

  // R1
  meter_on_needs_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    meter_en_o |-> (frck_en_o && ctrl_o[CODE_W]));

  // R1
  meter_window_chk: assert property (@(posedge clk) disable iff (rst)
    meter_en_o |-> (meter_window_o == WIN_FIELD_W'(WINDOW)));

  // R2
  frck_after_meter_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(meter_en_o) |=> $fell(frck_en_o));

  // R3
  timeout_during_meter_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_o) |-> meter_en_o);

  // R7
  osc_off_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl_o[CODE_W]) |-> done_o);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!meter_en_o && !frck_en_o && !ctrl_o[CODE_W]));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

bind srcal_seq srcal_seq_chk #(
  .CODE_W      (CODE_W),
  .WINDOW      (WINDOW),
  .WIN_FIELD_W (WIN_FIELD_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctrl_o         (ctrl_o),
  .frck_en_o      (frck_en_o),
  .meter_en_o     (meter_en_o),
  .meter_window_o (meter_window_o),
  .done_o         (done_o),
  .timeout_o      (timeout_o)
);

// File: tb/srcal_seq_tb.sv
module srcal_seq_tb;

  localparam int CLK_MHZ = 10;
  localparam int SET     = CLK_MHZ * 1;
  localparam int POLL    = CLK_MHZ * 10;
  localparam int NPOLL   = 20;
  localparam int NV      = 10;

  typedef struct packed {
    logic [2:0]  frc;
    logic [15:0] ref_m;
    logic [15:0] coef;
    logic [23:0] cnt;
    logic        valid;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd26, 16'd17, 24'd150,     1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd100,     1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd80,      1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd60,      1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd0,       1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd600,     1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd1000000, 1'b1},
    '{3'd0, 16'd50, 16'd20, 24'd200,     1'b1},
    '{3'd0, 16'd26, 16'd17, 24'd120,     1'b0},
    '{3'd5, 16'd26, 16'd17, 24'd100,     1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  force_code = '0;
  logic [15:0] ref_mhz = 16'd26;
  logic [15:0] coef = 16'd17;
  logic        want_valid = 1'b0;
  logic        meter_valid;
  logic [23:0] meter_count = '0;
  logic [3:0]  ctrl_o;
  logic        frck_en_o, meter_en_o, done_o, timeout_o;
  logic [23:0] meter_window_o;
  logic [2:0]  code_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  assign meter_valid = meter_en_o & want_valid;

  srcal_seq #(.CLK_MHZ(CLK_MHZ)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start),
    .force_code_i   (force_code),
    .ref_mhz_i      (ref_mhz),
    .coef_i         (coef),
    .meter_valid_i  (meter_valid),
    .meter_count_i  (meter_count),
    .ctrl_o         (ctrl_o),
    .frck_en_o      (frck_en_o),
    .meter_en_o     (meter_en_o),
    .meter_window_o (meter_window_o),
    .done_o         (done_o),
    .code_o         (code_o),
    .timeout_o      (timeout_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input vec_t v);
    longint n, q, c;
    if (v.frc != 0) return int'(v.frc);
    if (v.cnt == 0) return 3;
    n = longint'(v.ref_m) * longint'(v.coef) * 1024;
    q = n / longint'(v.cnt);
    c = (q + 500) / 1000;
    if (c > 7) c = 7;
    return int'(c);
  endfunction

  task automatic run(input vec_t v, input bit mid);
    int k_meter = -1, k_moff = -1, k_foff = -1, k_done = -1, ndone = 0;
    bit osc_seen = 0, meter_seen = 0, win_ok = 1;
    string ctag;
    @(negedge clk);
    force_code  = v.frc;
    ref_mhz     = v.ref_m;
    coef        = v.coef;
    meter_count = v.cnt;
    want_valid  = v.valid;
    start       = 1'b1;
    for (int k = 1; k < 6000; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (mid && k == SET + 20) begin start = 1'b1; force_code = 3'd6; end
      if (mid && k == SET + 21) start = 1'b0;
      if (meter_en_o && k_meter < 0) k_meter = k;
      if (meter_en_o && meter_window_o != 24'd1024) win_ok = 0;
      if (k_meter >= 0 && !meter_en_o && k_moff < 0) k_moff = k;
      if (k_moff >= 0 && !frck_en_o && k_foff < 0) k_foff = k;
      if (ctrl_o[3]) osc_seen = 1;
      if (meter_en_o) meter_seen = 1;
      if (done_o) begin ndone++; if (k_done < 0) k_done = k; end
      if (k_done >= 0 && k >= k_done + 4) break;
    end
    chk(ndone == 1, mid ? "R9 done count" : "R8 done count", ndone, 1);
    if (v.frc != 0) begin
      chk(k_done == 3, "R6 forced done latency", k_done, 3);
      chk(!osc_seen && !meter_seen, "R6 no activity", osc_seen + meter_seen, 0);
    end else begin
      chk(k_meter == SET + 2, mid ? "R9 meter timing" : "R1 meter enable latency", k_meter, SET + 2);
      chk(win_ok, "R1 window value", meter_window_o, 1024);
      if (v.valid)
        chk(k_moff - k_meter == POLL + 1, "R2 poll duration", k_moff - k_meter, POLL + 1);
      else
        chk(k_moff - k_meter == NPOLL * POLL + 1, "R3 timeout duration", k_moff - k_meter, NPOLL * POLL + 1);
      chk(k_foff == k_moff + 1, "R2 frck off order", k_foff, k_moff + 1);
    end
    ctag = (v.frc != 0) ? "R6 code" : (v.cnt == 0) ? "R5 code" : mid ? "R9 code" : "R4 code";
    chk(code_o == exp_code(v), ctag, code_o, exp_code(v));
    chk(ctrl_o[2:0] == code_o, "R7 field", ctrl_o[2:0], code_o);
    chk(timeout_o == (!v.valid && v.frc == 0), "R3 timeout flag", timeout_o, (!v.valid && v.frc == 0));
    chk(!ctrl_o[3] && !frck_en_o && !meter_en_o, "R7 idle outputs", {ctrl_o[3], frck_en_o, meter_en_o}, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(ctrl_o == 0 && !frck_en_o && !meter_en_o && meter_window_o == 0 && !done_o
        && code_o == 0 && !timeout_o, "R10 reset state", {ctrl_o, frck_en_o, meter_en_o, done_o}, 0);

    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

    // R9: second start during a running measurement is ignored
    run(VECS[1], 1'b1);

    // R7: code held with no start
    repeat (50) @(negedge clk);
    chk(code_o == 3'd5 && ctrl_o == 4'd5, "R7 code hold", ctrl_o, 5);

    // R3: timeout flag cleared by next accepted start
    run(VECS[8], 1'b0);
    run(VECS[0], 1'b0);

    summary();
    $finish;
  end

endmodule